// File: doc/BRIEF.md
# Minimum-Energy Supply Reference Tracker

This controller searches for the supply code at which a digital load uses the least energy per operation. It assumes that energy plotted against supply voltage has one minimum. A run begins with a start request from a system controller or a periodic timer. The controller drives a reference code to an external regulator and waits a programmable number of cycles so the supply can settle. It then asks an external energy estimator for a measurement through a request/acknowledge handshake and compares the result with the lowest energy seen so far.

The search first steps upward from the initial code. If that first step costs more energy, the search turns round and walks downward from just below the initial code. In either direction, the first measurement that is not lower than the stored minimum ends the run. The reference moves back one code to the best point and the controller locks. The code is always kept between programmable lower and upper bounds, and reaching a bound also ends the search. A new start request re-arms the search, so the supply can follow drift in temperature or workload.

Top module: `mep_tracker`

## Requirements
- R1: While reset is active and after it is released: ref_code_o = 0, busy_o = 0, locked_o = 0, meas_req_o = 0.
- R2: A start_i sampled high while not busy loads the initial code, clamped into [min_code_i, max_code_i], into ref_code_o on that edge. busy_o = 1 and locked_o = 0 from the same edge. The first measurement is taken at this code.
- R3: After every change of ref_code_o (and after a start), meas_req_o rises only after ref_code_o has been held for at least settle_cycles_i clock cycles.
- R4: meas_req_o stays high, with ref_code_o unchanged, until meas_ack_i is sampled high. energy_i is taken on that same edge.
- R5: After the first measurement the code goes up by one. While each new result is strictly lower than the stored minimum, the minimum is replaced and the code keeps rising by one.
- R6: If the first step up is not strictly lower, the next measurement is taken at the initial code minus one. The search then keeps falling by one while results are strictly lower.
- R7: In either direction, the first result that is not strictly lower (a tie counts as not lower) moves the code one step back, to the best code found, and locks.
- R8: A search that reaches max_code_i going up, or min_code_i going down, locks at that bound. This also applies when the clamped initial code is already at the bound in the direction of travel.
- R9: When locked: locked_o = 1, busy_o = 0, meas_req_o = 0, and ref_code_o holds until the next start.
- R10: start_i is ignored while busy_o = 1. The ongoing search and its result are unchanged.
- R11: A start from the locked state runs a complete new search from the new initial code, with a fresh minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or re-arm request |
| init_code_i | input | CODE_W | Initial reference code |
| min_code_i | input | CODE_W | Lowest permitted code |
| max_code_i | input | CODE_W | Highest permitted code |
| settle_cycles_i | input | SETTLE_W | Settle wait in clock cycles |
| meas_req_o | output | 1 | Measurement request to the energy estimator |
| meas_ack_i | input | 1 | Measurement done; energy_i is valid |
| energy_i | input | ENERGY_W | Energy-per-operation estimate |
| ref_code_o | output | CODE_W | Supply reference code |
| busy_o | output | 1 | Search in progress |
| locked_o | output | 1 | Search finished; reference holds the result |

## Verification
The assertions assume the following about the inputs:
- min_code_i is at most max_code_i.
- Both bounds, together with settle_cycles_i, stay constant while busy_o is high.
- The estimator answers each request with exactly one acknowledge cycle.

The bench's estimator keeps to these rules. It changes bounds and settle time only while the controller is idle or locked, and it answers every request with a single acknowledge pulse after a fixed latency. Its energy values come from a parabola around a chosen code, or from a flat curve, evaluated at the code currently driven.

// File: rtl/mep_pkg.sv
package mep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEAS,
    ST_LOCK
  } state_e;

  typedef enum logic [1:0] {
    PH_INIT,
    PH_PROBE,
    PH_UP,
    PH_DOWN
  } phase_e;
endpackage

// File: rtl/mep_settle_timer.sv
module mep_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] cycles_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= cycles_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mep_code_step.sv
module mep_code_step #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] raw_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  output logic [CODE_W-1:0] inc_o,
  output logic [CODE_W-1:0] dec_o,
  output logic [CODE_W-1:0] clamped_o,
  output logic              at_hi_o,
  output logic              at_lo_o
);
  assign at_hi_o = (code_i >= hi_i);
  assign at_lo_o = (code_i <= lo_i);
  assign inc_o   = at_hi_o ? code_i : code_i + 1'b1;
  assign dec_o   = at_lo_o ? code_i : code_i - 1'b1;

  always_comb begin
    if (raw_i > hi_i)      clamped_o = hi_i;
    else if (raw_i < lo_i) clamped_o = lo_i;
    else                   clamped_o = raw_i;
  end
endmodule

// File: rtl/mep_emin_reg.sv
module mep_emin_reg #(
  parameter int ENERGY_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ENERGY_W-1:0] energy_i,
  output logic                lower_o
);
  logic [ENERGY_W-1:0] emin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     emin_q <= '1;
    else if (load_i) emin_q <= energy_i;
  end

  // strict compare: a tie is treated as not lower
  assign lower_o = (energy_i < emin_q);
endmodule

// File: rtl/mep_tracker.sv
module mep_tracker #(
  parameter int CODE_W   = 6,
  parameter int ENERGY_W = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CODE_W-1:0]   init_code_i,
  input  logic [CODE_W-1:0]   min_code_i,
  input  logic [CODE_W-1:0]   max_code_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic                meas_req_o,
  input  logic                meas_ack_i,
  input  logic [ENERGY_W-1:0] energy_i,
  output logic [CODE_W-1:0]   ref_code_o,
  output logic                busy_o,
  output logic                locked_o
);
  import mep_pkg::*;

  state_e state_q, state_d;
  phase_e phase_q, phase_d;
  logic [CODE_W-1:0] ref_q, ref_d, init_q, init_d;
  logic [CODE_W-1:0] inc_w, dec_w, clamp_w;
  logic at_hi_w, at_lo_w, lower_w, expired_w;
  logic ld_settle, emin_load;

  mep_code_step #(.CODE_W(CODE_W)) u_step (
    .code_i   (ref_q),
    .raw_i    (init_code_i),
    .lo_i     (min_code_i),
    .hi_i     (max_code_i),
    .inc_o    (inc_w),
    .dec_o    (dec_w),
    .clamped_o(clamp_w),
    .at_hi_o  (at_hi_w),
    .at_lo_o  (at_lo_w)
  );

  mep_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ld_settle),
    .cycles_i (settle_cycles_i),
    .expired_o(expired_w)
  );

  mep_emin_reg #(.ENERGY_W(ENERGY_W)) u_emin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emin_load),
    .energy_i(energy_i),
    .lower_o (lower_w)
  );

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    ref_d     = ref_q;
    init_d    = init_q;
    ld_settle = 1'b0;
    emin_load = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_LOCK: begin
        if (start_i) begin
          ref_d     = clamp_w;
          init_d    = clamp_w;
          phase_d   = PH_INIT;
          state_d   = ST_SETTLE;
          ld_settle = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (expired_w) state_d = ST_MEAS;
      end
      ST_MEAS: begin
        if (meas_ack_i) begin
          state_d = ST_LOCK;
          unique case (phase_q)
            PH_INIT: begin
              emin_load = 1'b1;
              if (!at_hi_w) begin
                ref_d = inc_w; phase_d = PH_PROBE;
                state_d = ST_SETTLE; ld_settle = 1'b1;
              end
            end
            PH_PROBE: begin
              if (lower_w) begin
                emin_load = 1'b1;
                if (!at_hi_w) begin
                  ref_d = inc_w; phase_d = PH_UP;
                  state_d = ST_SETTLE; ld_settle = 1'b1;
                end
              end else if (init_q <= min_code_i) begin
                ref_d = init_q;
              end else begin
                // skip the start point: its energy is already stored
                ref_d = init_q - 1'b1; phase_d = PH_DOWN;
                state_d = ST_SETTLE; ld_settle = 1'b1;
              end
            end
            PH_UP: begin
              if (lower_w) begin
                emin_load = 1'b1;
                if (!at_hi_w) begin
                  ref_d = inc_w; state_d = ST_SETTLE; ld_settle = 1'b1;
                end
              end else begin
                ref_d = dec_w;
              end
            end
            PH_DOWN: begin
              if (lower_w) begin
                emin_load = 1'b1;
                if (!at_lo_w) begin
                  ref_d = dec_w; state_d = ST_SETTLE; ld_settle = 1'b1;
                end
              end else begin
                ref_d = inc_w;
              end
            end
            default: ;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_INIT;
      ref_q   <= '0;
      init_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      ref_q   <= ref_d;
      init_q  <= init_d;
    end
  end

  assign ref_code_o = ref_q;
  assign meas_req_o = (state_q == ST_MEAS);
  assign busy_o     = (state_q == ST_SETTLE) || (state_q == ST_MEAS);
  assign locked_o   = (state_q == ST_LOCK);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && !meas_ack_i |=> meas_req_o);

  // R4
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && !meas_ack_i |=> $stable(ref_code_o));

  // R8
  ref_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ref_code_o >= min_code_i) && (ref_code_o <= max_code_i));

  // R9
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !start_i |=> locked_o && !meas_req_o && $stable(ref_code_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(meas_req_o && meas_ack_i) |=> busy_o);
endmodule

// File: tb/mep_tracker_test.sv
module mep_tracker_test;
  localparam int CW = 6;
  localparam int EW = 16;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] init_code_i = '0, min_code_i = '0, max_code_i = '1;
  logic [SW-1:0] settle_cycles_i = '0;
  logic meas_req_o, meas_ack_i = 1'b0;
  logic [EW-1:0] energy_i = '0;
  logic [CW-1:0] ref_code_o;
  logic busy_o, locked_o;

  always #10 clk = ~clk;

  mep_tracker #(.CODE_W(CW), .ENERGY_W(EW), .SETTLE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .init_code_i(init_code_i), .min_code_i(min_code_i), .max_code_i(max_code_i),
    .settle_cycles_i(settle_cycles_i), .meas_req_o(meas_req_o),
    .meas_ack_i(meas_ack_i), .energy_i(energy_i), .ref_code_o(ref_code_o),
    .busy_o(busy_o), .locked_o(locked_o)
  );

  int errors = 0, checks = 0;
  int ctr = 0;
  bit flat = 0;
  int s_cur = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int energy_of(int c);
    if (flat) return 500;
    return 100 + 3 * (c - ctr) * (c - ctr);
  endfunction

  // estimator: single ack pulse after fixed latency
  initial begin
    forever begin
      @(negedge clk);
      if (meas_req_o && !meas_ack_i) begin
        repeat (2) @(negedge clk);
        energy_i   = EW'(energy_of(int'(ref_code_o)));
        meas_ack_i = 1'b1;
        @(negedge clk);
        meas_ack_i = 1'b0;
      end
    end
  end

  // monitor: pops expected measurement codes on each request
  logic prev_req = 1'b0;
  logic [CW-1:0] last_ref = '0;
  int stable_cnt = 0;
  always @(negedge clk) begin
    if (ref_code_o != last_ref) stable_cnt = 0;
    else stable_cnt++;
    last_ref = ref_code_o;
    if (rst_ni && meas_req_o && !prev_req) begin
      // R3 settle wait
      chk(stable_cnt >= s_cur, "R3 settle", stable_cnt, s_cur);
      if (exp_q.size() == 0) begin
        chk(0, "R5/R6 unexpected measurement", int'(ref_code_o), -1);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(int'(ref_code_o) == e, t, int'(ref_code_o), e);
      end
    end
    prev_req = meas_req_o;
  end

  // driver-side expectation of the search walk
  task automatic build_expect(int init, int lo, int hi, output int fin);
    int c, emin, e;
    c = (init > hi) ? hi : (init < lo) ? lo : init;
    exp_q.push_back(c); tag_q.push_back("R2 first code");
    emin = energy_of(c);
    if (c >= hi) begin fin = c; return; end
    c = c + 1; exp_q.push_back(c); tag_q.push_back("R5 step up");
    e = energy_of(c);
    if (e < emin) begin
      emin = e;
      forever begin
        if (c >= hi) begin fin = c; return; end
        c = c + 1; exp_q.push_back(c); tag_q.push_back("R5 keep rising");
        e = energy_of(c);
        if (e < emin) emin = e;
        else begin fin = c - 1; return; end
      end
    end else begin
      c = c - 1;
      if (c <= lo) begin fin = c; return; end
      c = c - 1; exp_q.push_back(c); tag_q.push_back("R6 reverse");
      forever begin
        e = energy_of(c);
        if (e < emin) begin
          emin = e;
          if (c <= lo) begin fin = c; return; end
          c = c - 1; exp_q.push_back(c); tag_q.push_back("R6 keep falling");
        end else begin fin = c + 1; return; end
      end
    end
  endtask

  task automatic run_case(int init, int lo, int hi, int s, int center, bit fl,
                          bit poke, int exp_fin, string req);
    int fin, guard, clamped;
    logic [CW-1:0] held;
    @(negedge clk);
    ctr = center; flat = fl; s_cur = s;
    init_code_i = CW'(init); min_code_i = CW'(lo); max_code_i = CW'(hi);
    settle_cycles_i = SW'(s);
    build_expect(init, lo, hi, fin);
    chk(fin == exp_fin, {req, " model"}, fin, exp_fin);
    clamped = (init > hi) ? hi : (init < lo) ? lo : init;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2 start loads clamped code
    chk(busy_o && !locked_o, "R2 busy", int'(busy_o), 1);
    chk(int'(ref_code_o) == clamped, "R2 clamped init", int'(ref_code_o), clamped);
    if (poke) begin
      repeat (3) @(negedge clk);
      init_code_i = CW'(init ^ 5);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      init_code_i = CW'(init);
      // R10 still busy after ignored start
      chk(busy_o, "R10 start ignored", int'(busy_o), 1);
    end
    guard = 0;
    while (!locked_o && guard < 5000) begin @(negedge clk); guard++; end
    chk(exp_q.size() == 0, "R5/R6 all measurements seen", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    chk(int'(ref_code_o) == exp_fin, req, int'(ref_code_o), exp_fin);
    held = ref_code_o;
    repeat (10) @(negedge clk);
    // R9 locked and quiet
    chk(locked_o && !busy_o && !meas_req_o, "R9 lock status", int'(locked_o), 1);
    chk(ref_code_o == held, "R9 code held", int'(ref_code_o), int'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ref_code_o == '0 && !busy_o && !locked_o && !meas_req_o, "R1 reset", int'(ref_code_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(ref_code_o == '0 && !busy_o && !locked_o && !meas_req_o, "R1 after release", int'(busy_o), 0);

    run_case(20, 8, 40, 3, 25, 0, 0, 25, "R7 up walk result");
    run_case(20, 8, 40, 0, 14, 0, 0, 14, "R11 rearm reverse result R6");
    run_case(20, 8, 40, 2, 20, 0, 0, 20, "R7 minimum at start");
    run_case(35, 8, 40, 1, 50, 0, 0, 40, "R8 upper bound");
    run_case(12, 8, 40, 1, 2, 0, 0, 8, "R8 lower bound");
    run_case(60, 8, 40, 4, 30, 0, 0, 40, "R8 init clamped to max");
    run_case(3, 8, 40, 0, 2, 0, 0, 8, "R8 init clamped to min");
    run_case(20, 8, 40, 2, 0, 1, 0, 20, "R7 tie stops");
    run_case(18, 8, 40, 5, 23, 0, 1, 23, "R10 result unchanged");
    run_case(30, 8, 40, 1, 27, 0, 0, 27, "R11 drift rearm");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule